// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block walks a byte-level I2C master engine through one whole transaction. A single start request selects the transaction kind, the target address and its width (7 or 10 bit), and the lengths of two byte buffers. The sequencer then builds the address header bytes and fetches outgoing bytes through a plain buffer read port. It stores incoming bytes through the same port's write side. Bus commands go to the engine as one-cycle pulses: START, STOP, ACK, NACK, abort, clear and flush, and a transmit-byte load. The block reacts to the engine's one-cycle event pulses.

The engine reports ACK, NACK, byte received, stop finished, arbitration lost and bus error. The sequencer arms NACK early, so that the last byte of a read is refused. It inserts a repeated START where a 10-bit read or a write-then-read needs one. It reports a result code that stays stable until the next request.

Top module: `i2c_xfer_seq`

## Requirements
- R1: For a 7-bit address, the header byte is `{addr[7:1], rd}`, where rd is 1 only for a plain read. The kind codes are 0 write, 1 read, 2 write-then-write and 3 write-then-read. For the first START, the header is loaded one cycle before the START pulse.
- R2: For a 10-bit address, the first header is `{5'b11110, addr[9:8], 1'b0}`, which always means write. Once it is ACKed, `addr[7:0]` is loaded as the second byte.
- R3: In a 10-bit plain read, the ACK of the second address byte leads to a repeated START. The header with bit 0 set is loaded in the following cycle, so on a repeated START the START pulse always comes before the load.
- R4: Write-then-read sends every byte of buffer 0. It then issues a repeated START, loads the header with bit 0 set, and receives into buffer 1.
- R5: Write-then-write sends buffer 0 and then buffer 1 with no START between them, then pulses STOP.
- R6: A start request with a zero read length is rejected. This means kind 1 with length 0 of zero, or kind 3 with length 1 of zero. The result becomes 5 one cycle later, no command is pulsed and busy stays low.
- R7: Each received byte is written at `(buffer, index)`. Every byte but the last is ACKed. NACK is pulsed along with the ACK of the next-to-last byte. For a one-byte read, NACK is pulsed instead with the 7-bit header load or with the repeated START. STOP follows the last byte.
- R8: A NACK event while awaiting an address or data acknowledge pulses STOP in the next cycle and sets the result to 2. Busy stays high until the stop-done event and falls one cycle after it.
- R9: Arbitration lost gives result 3 and bus error gives result 4. Either one drops busy one cycle after the event, with no STOP.
- R10: A start request pulses clear and flush in the next cycle. If the engine reports busy during the request, it also pulses abort.
- R11: The result codes are 0 none (the reset value), 1 done, 2 NACK, 3 arbitration lost, 4 bus error and 5 usage fault. Busy is high whenever a transaction is under way. The result holds while idle until the next start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Start pulse, accepted while idle |
| kind | input | 2 | Transaction kind (R1 codes) |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| tgt_addr | input | 10 | Target address |
| len0 | input | LEN_W | Byte count of buffer 0 |
| len1 | input | LEN_W | Byte count of buffer 1 |
| eng_busy | input | 1 | Engine reports busy |
| ev_ack | input | 1 | Byte acknowledged |
| ev_nack | input | 1 | Byte not acknowledged |
| ev_rxbyte | input | 1 | Byte received |
| rx_byte | input | 8 | Received byte |
| ev_stop_done | input | 1 | STOP finished on the bus |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Misplaced START/STOP seen |
| cmd_start | output | 1 | START / repeated START pulse |
| cmd_stop | output | 1 | STOP pulse |
| cmd_ack | output | 1 | ACK current received byte |
| cmd_nack | output | 1 | Arm NACK |
| cmd_abort | output | 1 | Abort engine activity |
| cmd_clear | output | 1 | Clear transmit and pending commands |
| cmd_flush | output | 1 | Flush stale receive data |
| tx_load | output | 1 | Load `tx_byte` into the engine |
| tx_byte | output | 8 | Byte to transmit |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_buf | output | 1 | Buffer select |
| mem_idx | output | LEN_W | Byte index in buffer |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte read, same cycle |
| busy | output | 1 | Transaction in progress |
| result | output | 3 | Result code (R11) |

## Verification
All engine commands are registered. A command caused by an event shows up on the clock edge that samples the event, so the bench sees it at the next falling edge. Buffer strobes are combinational and are seen in the same cycle as the event, so the bench samples them just after it drives the event. The bench model is behavioural: it builds the expected command transcript, including byte values and buffer positions, and compares every pulse as it appears. A busy fall or result change is due exactly one cycle after the terminating event (stop-done, arbitration lost or bus error). A usage fault is due one cycle after the request, and the bench checks those cycle numbers.

// File: rtl/i2cseq_pkg.sv
// Shared types of the I2C transaction sequencer.
package i2cseq_pkg;
    typedef enum logic [1:0] {K_WRITE = 2'd0, K_READ = 2'd1, K_WRWR = 2'd2, K_WRRD = 2'd3} kind_t;
    typedef enum logic [2:0] {RES_NONE = 3'd0, RES_DONE = 3'd1, RES_NACK = 3'd2,
                              RES_ARB = 3'd3, RES_BUSERR = 3'd4, RES_USAGE = 3'd5} res_t;
    typedef enum logic [3:0] {S_IDLE, S_HDR, S_HDR2, S_WA1, S_WA2, S_RS1, S_RS2,
                              S_WRA, S_SEND, S_WD, S_RECV, S_WSTOP} st_t;
endpackage

// File: rtl/i2cseq_hdr.sv
// Address header formatter: builds the first address byte for 7-bit or
// 10-bit targets. Purely combinational; assumes the caller picks rd.
module i2cseq_hdr (
    input  logic       ten,
    input  logic [9:1] addr_hi,
    input  logic       rd,
    output logic [7:0] hdr_byte
);
    // Select the header layout for the address width.
    always_comb begin
        if (ten) hdr_byte = {5'b11110, addr_hi[9:8], rd};
        else     hdr_byte = {addr_hi[7:1], rd};
    end
endmodule

// File: rtl/i2cseq_ptr.sv
// Buffer pointer: tracks the active buffer and byte index, and decodes the
// end, last and next-to-last positions against the active length.
// Assumes clr, nxt and inc are never requested in the same cycle.
module i2cseq_ptr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             nxt,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] len0,
    input  logic [LEN_W-1:0] len1,
    output logic             buf_sel,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] cur_len,
    output logic             at_end,
    output logic             is_last,
    output logic             is_penult
);
    logic [LEN_W:0] idx_x;
    logic [LEN_W:0] len_x;

    // Decode the position against the active buffer length.
    always_comb begin
        cur_len   = buf_sel ? len1 : len0;
        idx_x     = {1'b0, idx};
        len_x     = {1'b0, cur_len};
        at_end    = idx_x >= len_x;
        is_last   = (idx_x + 1'b1) >= len_x;
        is_penult = (idx_x + 2'd2) == len_x;
    end

    // Advance, switch or clear the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            buf_sel <= 1'b0;
            idx     <= '0;
        end else if (nxt) begin
            buf_sel <= 1'b1;
            idx     <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (idx < cur_len)); // R7
endmodule

// File: rtl/i2c_xfer_seq.sv
// I2C master transaction sequencer. Drives a byte-level engine through one
// transaction per start request. Assumes engine events are one-cycle pulses
// and the buffer read port answers in the same cycle.
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [1:0]       kind,
    input  logic             ten_bit,
    input  logic [9:0]       tgt_addr,
    input  logic [LEN_W-1:0] len0,
    input  logic [LEN_W-1:0] len1,
    input  logic             eng_busy,
    input  logic             ev_ack,
    input  logic             ev_nack,
    input  logic             ev_rxbyte,
    input  logic [7:0]       rx_byte,
    input  logic             ev_stop_done,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err,
    output logic             cmd_start,
    output logic             cmd_stop,
    output logic             cmd_ack,
    output logic             cmd_nack,
    output logic             cmd_abort,
    output logic             cmd_clear,
    output logic             cmd_flush,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_buf,
    output logic [LEN_W-1:0] mem_idx,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic [2:0]       result
);
    st_t              st;
    kind_t            k_kind;
    logic             k_ten;
    logic [9:0]       k_addr;
    logic [LEN_W-1:0] k_len0, k_len1;
    res_t             res_q;

    logic             err, usage_bad, ack_wait, hdr_rd;
    logic             p_clr, p_inc, p_nxt;
    logic             buf_sel, at_end, is_last, is_penult;
    logic [LEN_W-1:0] idx, cur_len;
    logic [7:0]       hdr_byte;

    i2cseq_ptr #(.LEN_W(LEN_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .nxt(p_nxt),
        .wr_en(mem_wr), .len0(k_len0), .len1(k_len1), .buf_sel(buf_sel),
        .idx(idx), .cur_len(cur_len), .at_end(at_end), .is_last(is_last),
        .is_penult(is_penult)
    );

    i2cseq_hdr u_hdr (
        .ten(k_ten), .addr_hi(k_addr[9:1]), .rd(hdr_rd), .hdr_byte(hdr_byte)
    );

    // Decode events, pointer controls and buffer strobes.
    always_comb begin
        err       = ev_arb_lost | ev_bus_err;
        usage_bad = (kind == K_READ && len0 == '0) || (kind == K_WRRD && len1 == '0);
        ack_wait  = (st == S_WA1) || (st == S_WA2) || (st == S_WRA) || (st == S_WD);
        hdr_rd    = (st == S_RS2) || (k_kind == K_READ && !k_ten);
        p_clr     = (st == S_IDLE) && start_req;
        p_inc     = !err && (((st == S_SEND) && !at_end) || ((st == S_RECV) && ev_rxbyte));
        p_nxt     = !err && (st == S_SEND) && at_end && !buf_sel &&
                    (k_kind == K_WRRD || k_kind == K_WRWR);
        mem_rd    = (st == S_SEND) && !at_end;
        mem_wr    = (st == S_RECV) && ev_rxbyte && !err;
        mem_buf   = buf_sel;
        mem_idx   = idx;
        mem_wdata = rx_byte;
        busy      = (st != S_IDLE);
        result    = res_q;
    end

    // Transaction state machine with registered command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  res_q <= RES_NONE;  k_kind <= K_WRITE;  k_ten <= 1'b0;
            k_addr <= '0;  k_len0 <= '0;  k_len1 <= '0;  tx_byte <= '0;
            cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_ack <= 1'b0; cmd_nack <= 1'b0;
            cmd_abort <= 1'b0; cmd_clear <= 1'b0; cmd_flush <= 1'b0; tx_load <= 1'b0;
        end else begin
            cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_ack <= 1'b0; cmd_nack <= 1'b0;
            cmd_abort <= 1'b0; cmd_clear <= 1'b0; cmd_flush <= 1'b0; tx_load <= 1'b0;
            if (st != S_IDLE && err) begin
                res_q <= ev_arb_lost ? RES_ARB : RES_BUSERR;
                st    <= S_IDLE;
            end else if (ack_wait && ev_nack) begin
                res_q    <= RES_NACK;
                cmd_stop <= 1'b1;
                st       <= S_WSTOP;
            end else begin
                case (st)
                    S_IDLE: if (start_req) begin
                        k_kind <= kind_t'(kind);  k_ten <= ten_bit;  k_addr <= tgt_addr;
                        k_len0 <= len0;  k_len1 <= len1;
                        if (usage_bad) begin
                            res_q <= RES_USAGE;
                        end else begin
                            res_q     <= RES_NONE;
                            cmd_abort <= eng_busy;
                            cmd_clear <= 1'b1;
                            cmd_flush <= 1'b1;
                            st        <= S_HDR;
                        end
                    end
                    S_HDR: begin
                        tx_byte  <= hdr_byte;
                        tx_load  <= 1'b1;
                        cmd_nack <= (k_kind == K_READ) && !k_ten && (cur_len == LEN_W'(1));
                        st       <= S_HDR2;
                    end
                    S_HDR2: begin
                        cmd_start <= 1'b1;
                        st        <= S_WA1;
                    end
                    S_WA1: if (ev_ack) begin
                        if (k_ten) begin
                            tx_byte <= k_addr[7:0];
                            tx_load <= 1'b1;
                            st      <= S_WA2;
                        end else begin
                            st <= (k_kind == K_READ) ? S_RECV : S_SEND;
                        end
                    end
                    S_WA2: if (ev_ack) st <= (k_kind == K_READ) ? S_RS1 : S_SEND;
                    S_RS1: begin
                        cmd_start <= 1'b1;
                        cmd_nack  <= (cur_len == LEN_W'(1));
                        st        <= S_RS2;
                    end
                    S_RS2: begin
                        tx_byte <= hdr_byte;
                        tx_load <= 1'b1;
                        st      <= S_WRA;
                    end
                    S_WRA: if (ev_ack) st <= S_RECV;
                    S_SEND: begin
                        if (at_end) begin
                            if (!buf_sel && k_kind == K_WRRD) begin
                                st <= S_RS1;
                            end else if (!(!buf_sel && k_kind == K_WRWR)) begin
                                cmd_stop <= 1'b1;
                                st       <= S_WSTOP;
                            end
                        end else begin
                            tx_byte <= mem_rdata;
                            tx_load <= 1'b1;
                            st      <= S_WD;
                        end
                    end
                    S_WD: if (ev_ack) st <= S_SEND;
                    S_RECV: if (ev_rxbyte) begin
                        if (is_last) begin
                            cmd_stop <= 1'b1;
                            st       <= S_WSTOP;
                        end else begin
                            cmd_ack  <= 1'b1;
                            cmd_nack <= is_penult;
                        end
                    end
                    S_WSTOP: if (ev_stop_done) begin
                        st <= S_IDLE;
                        if (res_q == RES_NONE) res_q <= RES_DONE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    AST_START_LOAD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, tx_load})); // R3
    AST_ERR_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err) |=> (!busy && !cmd_stop)); // R9
    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wait && ev_nack && !err) |=> (cmd_stop && result == 3'd2)); // R8
    AST_USAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && usage_bad) |=> (!busy && result == 3'd5 && !cmd_clear)); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req) |=> $stable(result)); // R11
endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int OP_ABORT = 1, OP_CLEAR = 2, OP_FLUSH = 3, OP_TXLOAD = 4,
                   OP_START = 5, OP_ACK = 6, OP_NACK = 7, OP_STOP = 8, OP_MEMWR = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 0, ten_bit = 0, eng_busy = 0;
    logic [1:0] kind = 0;
    logic [9:0] tgt_addr = 0;
    logic [LW-1:0] len0 = 0, len1 = 0;
    logic ev_ack = 0, ev_nack = 0, ev_rxbyte = 0, ev_stop_done = 0, ev_arb_lost = 0, ev_bus_err = 0;
    logic [7:0] rx_byte = 0;
    logic cmd_start, cmd_stop, cmd_ack, cmd_nack, cmd_abort, cmd_clear, cmd_flush, tx_load;
    logic [7:0] tx_byte, mem_wdata, mem_rdata;
    logic mem_rd, mem_wr, mem_buf, busy;
    logic [LW-1:0] mem_idx;
    logic [2:0] result;

    logic [7:0] m0 [16];
    logic [7:0] m1 [16];
    assign mem_rdata = mem_buf ? m1[mem_idx] : m0[mem_idx];

    i2c_xfer_seq #(.LEN_W(LW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int exp_q [$];
    int exp_res, rd_hdr_tx, nack_tx, err_tx, term_cyc;
    bit err_arb;
    int txn, rxn, ack_cd, rx_cd, stop_cd, resp_kind, resp_idx;
    string cur_req = "R11";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int enc(int code, int b);
        return (code << 16) | b;
    endfunction

    task automatic see(int code, int b);
        if (exp_q.size() == 0) chk(0, cur_req, enc(code, b), 0, "unexpected command");
        else begin
            int e = exp_q.pop_front();
            chk(e == enc(code, b), cur_req, enc(code, b), e, "command transcript");
        end
    endtask

    // Behavioural engine: answers loads, reads and stops after three cycles.
    always @(negedge clk) begin
        ev_ack = 0; ev_nack = 0; ev_rxbyte = 0; ev_stop_done = 0; ev_arb_lost = 0; ev_bus_err = 0;
        if (ack_cd > 0) begin
            ack_cd--;
            if (ack_cd == 0) begin
                case (resp_kind)
                    0: ev_ack = 1;
                    1: ev_nack = 1;
                    2: begin ev_arb_lost = 1; term_cyc = cyc; end
                    default: begin ev_bus_err = 1; term_cyc = cyc; end
                endcase
                if (resp_kind == 0 && resp_idx == rd_hdr_tx) rx_cd = 3;
            end
        end
        if (rx_cd > 0) begin
            rx_cd--;
            if (rx_cd == 0) begin ev_rxbyte = 1; rx_byte = 8'hC0 + 8'(rxn); rxn++; end
        end
        if (stop_cd > 0) begin
            stop_cd--;
            if (stop_cd == 0) begin ev_stop_done = 1; term_cyc = cyc; end
        end
        if (rst_n) begin
            if (cmd_abort) see(OP_ABORT, 0);
            if (cmd_clear) see(OP_CLEAR, 0);
            if (cmd_flush) see(OP_FLUSH, 0);
            if (tx_load) begin
                see(OP_TXLOAD, tx_byte);
                resp_idx  = txn;
                resp_kind = (txn == err_tx) ? (err_arb ? 2 : 3) : (txn == nack_tx) ? 1 : 0;
                txn++;
                ack_cd = 3;
            end
            if (cmd_start) see(OP_START, 0);
            if (cmd_ack) begin see(OP_ACK, 0); rx_cd = 3; end
            if (cmd_nack) see(OP_NACK, 0);
            if (cmd_stop) begin see(OP_STOP, 0); stop_cd = 3; end
            #1;
            if (mem_wr) begin
                see(OP_MEMWR, (int'(mem_buf) << 12) | (int'(mem_idx) << 8) | int'(mem_wdata));
                if (mem_buf) m1[mem_idx] = mem_wdata; else m0[mem_idx] = mem_wdata;
            end
        end
    end

    function automatic bit resp(int t);
        if (t == err_tx) begin exp_res = err_arb ? 3 : 4; return 1; end
        if (t == nack_tx) begin exp_q.push_back(enc(OP_STOP, 0)); exp_res = 2; return 1; end
        return 0;
    endfunction

    function automatic void recv(int b, int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(enc(OP_MEMWR, (b << 12) | (i << 8) | (8'hC0 + i)));
            if (i == n - 1) exp_q.push_back(enc(OP_STOP, 0));
            else begin
                exp_q.push_back(enc(OP_ACK, 0));
                if (i == n - 2) exp_q.push_back(enc(OP_NACK, 0));
            end
        end
    endfunction

    // Builds the expected transcript of one transaction.
    function automatic void build(int k, bit ten, int a, int l0, int l1, bit eb);
        int t = 0;
        int h0 = ten ? (8'hF0 | ((a >> 7) & 6)) : ((a & 8'hFE) | (k == 1 ? 1 : 0));
        exp_q.delete();
        rd_hdr_tx = -1;
        exp_res = 1;
        if ((k == 1 && l0 == 0) || (k == 3 && l1 == 0)) begin exp_res = 5; return; end
        if (eb) exp_q.push_back(enc(OP_ABORT, 0));
        exp_q.push_back(enc(OP_CLEAR, 0));
        exp_q.push_back(enc(OP_FLUSH, 0));
        exp_q.push_back(enc(OP_TXLOAD, h0));
        if (!ten && k == 1 && l0 == 1) exp_q.push_back(enc(OP_NACK, 0));
        exp_q.push_back(enc(OP_START, 0));
        if (!ten && k == 1) rd_hdr_tx = 0;
        if (resp(t)) return;
        t++;
        if (ten) begin
            exp_q.push_back(enc(OP_TXLOAD, a & 8'hFF));
            if (resp(t)) return;
            t++;
        end
        if (k == 1) begin
            if (ten) begin
                exp_q.push_back(enc(OP_START, 0));
                if (l0 == 1) exp_q.push_back(enc(OP_NACK, 0));
                exp_q.push_back(enc(OP_TXLOAD, h0 | 1));
                rd_hdr_tx = t;
                if (resp(t)) return;
                t++;
            end
            recv(0, l0);
        end else begin
            for (int i = 0; i < l0; i++) begin
                exp_q.push_back(enc(OP_TXLOAD, m0[i]));
                if (resp(t)) return;
                t++;
            end
            if (k == 2)
                for (int i = 0; i < l1; i++) begin
                    exp_q.push_back(enc(OP_TXLOAD, m1[i]));
                    if (resp(t)) return;
                    t++;
                end
            if (k == 3) begin
                exp_q.push_back(enc(OP_START, 0));
                if (l1 == 1) exp_q.push_back(enc(OP_NACK, 0));
                exp_q.push_back(enc(OP_TXLOAD, ten ? (h0 | 1) : ((a & 8'hFE) | 1)));
                rd_hdr_tx = t;
                if (resp(t)) return;
                t++;
                recv(1, l1);
            end else begin
                exp_q.push_back(enc(OP_STOP, 0));
            end
        end
    endfunction

    task automatic run(string req, int k, bit ten, int a, int l0, int l1, bit eb,
                       int nk, int ek, bit earb);
        int n = 0;
        int done_cyc, held;
        cur_req = req; nack_tx = nk; err_tx = ek; err_arb = earb;
        txn = 0; rxn = 0; term_cyc = -1;
        for (int i = 0; i < 16; i++) begin m0[i] = 8'h10 + 8'(i); m1[i] = 8'h30 + 8'(i); end
        build(k, ten, a, l0, l1, eb);
        @(negedge clk); #3;
        kind = 2'(k); ten_bit = ten; tgt_addr = 10'(a); len0 = LW'(l0); len1 = LW'(l1);
        eng_busy = eb; start_req = 1;
        @(negedge clk); #3;
        start_req = 0; eng_busy = 0;
        if (exp_res == 5) begin
            chk(busy == 0, req, busy, 0, "busy after rejected request");
            chk(result == 3'd5, req, result, 5, "usage result");
        end else begin
            while (busy && n < 3000) begin @(negedge clk); #3; n++; end
            chk(n < 3000, req, n, 0, "transaction hung");
            done_cyc = cyc;
            chk(done_cyc == term_cyc + 1, req, done_cyc, term_cyc + 1, "busy fall cycle");
            chk(result == 3'(exp_res), req, result, exp_res, "result");
        end
        held = result;
        repeat (4) @(negedge clk);
        #3;
        chk(exp_q.size() == 0, req, exp_q.size(), 0, "missing commands");
        chk(result == 3'(held), "R11", result, held, "result held while idle");
    endtask

    initial begin
        ack_cd = 0; rx_cd = 0; stop_cd = 0; nack_tx = -1; err_tx = -1; rd_hdr_tx = -1;
        repeat (3) @(negedge clk);
        #3;
        chk(busy == 0 && result == 3'd0, "R11", {busy, result}, 0, "reset state");
        chk(!(cmd_start | cmd_stop | tx_load | cmd_clear), "R11", tx_load, 0, "reset commands");
        rst_n = 1;
        run("R1",  0, 0, 10'h05A, 3, 0, 0, -1, -1, 0);
        run("R1",  1, 0, 10'h05B, 3, 0, 0, -1, -1, 0);
        run("R7",  1, 0, 10'h034, 1, 0, 0, -1, -1, 0);
        run("R2",  0, 1, 10'h2A5, 2, 0, 0, -1, -1, 0);
        run("R10", 0, 0, 10'h022, 1, 0, 1, -1, -1, 0);
        run("R3",  1, 1, 10'h1C3, 2, 0, 0, -1, -1, 0);
        run("R3",  1, 1, 10'h3FF, 1, 0, 0, -1, -1, 0);
        run("R4",  3, 0, 10'h040, 2, 3, 0, -1, -1, 0);
        run("R4",  3, 1, 10'h155, 1, 1, 0, -1, -1, 0);
        run("R5",  2, 0, 10'h0A0, 2, 2, 0, -1, -1, 0);
        run("R5",  2, 0, 10'h0A0, 0, 3, 0, -1, -1, 0);
        run("R6",  1, 0, 10'h050, 0, 4, 0, -1, -1, 0);
        run("R6",  3, 1, 10'h050, 2, 0, 0, -1, -1, 0);
        run("R8",  0, 0, 10'h066, 3, 0, 0, 2, -1, 0);
        run("R8",  1, 0, 10'h067, 2, 0, 0, 0, -1, 0);
        run("R8",  3, 1, 10'h101, 1, 2, 0, 2, -1, 0);
        run("R9",  0, 0, 10'h070, 3, 0, 0, -1, 1, 1);
        run("R9",  2, 1, 10'h070, 1, 1, 0, -1, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule